// File: doc/BRIEF.md
# Suppressed-Carrier Costas Demodulator

This block rebuilds a suppressed 57 kHz subcarrier from a single sliced bit and turns it into a signed soft baseband stream. An external clocked comparator supplies the bit. The block takes it once per pulse of a sample strobe, and the strobe runs at four pulses per carrier cycle, locked to the carrier that the block regenerates. A numerically controlled phase accumulator moves by a quarter cycle on each strobe, plus a correction. Its two top bits select one of four quadrants. Those quadrants give the in-phase reference the signs +,0,−,0 and the quadrature reference the signs 0,+,0,−, so each mixer only has to pick a sign.

The two arm products are summed over a window of four strobes. Each window sum then passes through a first-order low-pass filter. The filtered in-phase arm is the soft output, and it is presented with a one-clock valid pulse once per window. A later integrate-and-dump stage completes the pulse shaping. The error term is the filtered quadrature value multiplied by the sign of the filtered in-phase value. A proportional-integral filter turns that error into a bounded per-strobe phase correction. The regenerated carrier leaves the block as a logic-level square wave.

Top module: `costas_demod`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears its state: `soft_i` becomes 0, `soft_valid` becomes 0 and `carrier_out` becomes 1. The phase restarts in the middle of quadrant 0, and the loop integrator and window counter are cleared, so a repeated stimulus after reset repeats its output sequence exactly.
- R2: At each strobe, `slice_in`=1 counts as +1 and 0 counts as −1. The quadrant q is the two top phase bits taken before the strobe's update. The in-phase arm adds the sample when q=0 and subtracts it when q=2. The quadrature arm adds it when q=1 and subtracts it when q=3. A constant input therefore gives window sums of zero and `soft_i` stays 0.
- R3: At the end of each window, every arm applies y ← y + ((T − y) >>> 2), using an arithmetic shift. T is 32 times the window sum, saturated to ±127. `soft_i` is the in-phase y and never reads −128.
- R4: `soft_valid` is high for exactly one clock, the clock after every fourth strobe counted from reset, and `soft_i` holds the value filtered at that window end.
- R5: At each window end, the error is −Q if the filtered I value is negative and +Q otherwise, where Q is the filtered quadrature value and both are taken before that window's update. A positive error speeds up the accumulator. The correction is bounded by ±CORR_MAX, which is below a sixteenth of a cycle, so carrier periods are always 3, 4 or 5 strobes. An input in phase with the in-phase reference first shortens a period to 3.
- R6: `carrier_out` is 1 in quadrants 0 and 1 and 0 in quadrants 2 and 3. It changes only in the clock after a strobe. With zero error its period is exactly four strobes, and its first rising edge follows the fourth strobe.
- R7: While `samp_en` is low, `slice_in` is ignored: `soft_i` and `carrier_out` keep their values and `soft_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| samp_en | input | 1 | Sample strobe, four pulses per carrier cycle |
| slice_in | input | 1 | Sliced comparator bit (1 = +1, 0 = −1) |
| soft_i | output | SOFT_W (8) | Signed filtered in-phase sample |
| soft_valid | output | 1 | One-clock pulse per four strobes |
| carrier_out | output | 1 | Regenerated carrier square wave |

## Verification
The assertions assume that reset is held low through at least one clock edge. They also assume `slice_in` matters only in clocks where `samp_en` is high. For that reason they judge cadence, stability and range only against strobes and never against the value of the input bit. The stimulus sends single-clock strobes three clocks apart and drives every input from the falling edge. Between strobes it inverts `slice_in`, so that any leak of the input outside a strobe would show up on the outputs.

// File: rtl/costas_pkg.sv
// Shared types and helpers for the Costas carrier demodulator.
// Assumes four samples per carrier cycle, so quadrant indices fully describe the references.
package costas_pkg;

    // Quadrant of the regenerated carrier: top two bits of the phase accumulator.
    typedef logic [1:0] quad_t;

    // True when the arm with selector 'arm' (0 = in-phase, 1 = quadrature) has a nonzero reference.
    function automatic logic ref_active(input quad_t q, input logic arm);
        return q[0] == arm;
    endfunction

    // True when the nonzero reference in this quadrant is negative.
    function automatic logic ref_negative(input quad_t q);
        return q[1];
    endfunction

endpackage

// File: rtl/costas_nco.sv
// Phase accumulator that advances once per sample strobe by a quarter cycle plus a signed correction.
// Assumes CORR_W < PHASE_W and that the correction magnitude stays well below a quarter cycle.
module costas_nco
    import costas_pkg::*;
#(
    parameter int PHASE_W = 16,
    parameter int CORR_W  = 13
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step_en,
    input  logic signed [CORR_W-1:0] corr,
    output quad_t                    quad,
    output logic                     carrier
);
    localparam logic [PHASE_W-1:0] QUARTER = PHASE_W'(1) << (PHASE_W - 2);
    localparam logic [PHASE_W-1:0] MID_Q0  = PHASE_W'(1) << (PHASE_W - 3);

    logic [PHASE_W-1:0] phase;
    logic [PHASE_W-1:0] corr_ext;

    // Sign-extend the correction to the accumulator width.
    always_comb corr_ext = {{(PHASE_W - CORR_W){corr[CORR_W-1]}}, corr};

    // Advance the phase on each strobe; restart in mid quadrant 0.
    always_ff @(posedge clk) begin
        if (!rst_n)       phase <= MID_Q0;
        else if (step_en) phase <= phase + QUARTER + corr_ext;
    end

    // Quadrant and square-wave carrier come from the top phase bits.
    always_comb begin
        quad    = phase[PHASE_W-1 -: 2];
        carrier = ~phase[PHASE_W-1];
    end
endmodule

// File: rtl/costas_arms.sv
// In-phase and quadrature arms: sign-select mixing, four-strobe window sum, first-order low-pass.
// Assumes win_end is only high together with step_en.
module costas_arms
    import costas_pkg::*;
#(
    parameter int SOFT_W    = 8,
    parameter int GAIN_SH   = 5,
    parameter int LPF_SHIFT = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   step_en,
    input  logic                   win_end,
    input  logic                   din,
    input  quad_t                  quad,
    output logic [1:0][SOFT_W-1:0] lpf_out
);
    localparam int ACC_W  = 4;
    localparam int BASE_W = (ACC_W + GAIN_SH > SOFT_W) ? (ACC_W + GAIN_SH) : SOFT_W;
    localparam int WIDE_W = BASE_W + 2;
    localparam logic signed [WIDE_W-1:0] SMAX = WIDE_W'((1 << (SOFT_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0]  ONE  = ACC_W'(1);

    for (genvar a = 0; a < 2; a++) begin : g_arm
        localparam logic SEL = 1'(a);

        logic signed [ACC_W-1:0]  contrib, acc, acc_nxt;
        logic signed [WIDE_W-1:0] scaled, target, y_ext, diff, y_new;
        logic signed [SOFT_W-1:0] y;

        // Mixer: +1/-1 sample times the +1/0/-1 reference reduces to a sign pick.
        always_comb begin
            if (!ref_active(quad, SEL))              contrib = '0;
            else if (din ^ ref_negative(quad))       contrib = ONE;
            else                                     contrib = -ONE;
            acc_nxt = acc + contrib;
        end

        // Window accumulator, restarted after each fourth strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)       acc <= '0;
            else if (step_en) acc <= win_end ? '0 : acc_nxt;
        end

        // Scale the window sum, saturate it, and compute the low-pass step.
        always_comb begin
            scaled = {{(WIDE_W - ACC_W){acc_nxt[ACC_W-1]}}, acc_nxt} <<< GAIN_SH;
            if (scaled > SMAX)       target = SMAX;
            else if (scaled < -SMAX) target = -SMAX;
            else                     target = scaled;
            y_ext = {{(WIDE_W - SOFT_W){y[SOFT_W-1]}}, y};
            diff  = target - y_ext;
            y_new = y_ext + (diff >>> LPF_SHIFT);
        end

        // Filter state updates once per window.
        always_ff @(posedge clk) begin
            if (!rst_n)                  y <= '0;
            else if (step_en && win_end) y <= y_new[SOFT_W-1:0];
        end

        assign lpf_out[a] = y;
    end
endmodule

// File: rtl/costas_loop_filter.sv
// Costas phase detector and proportional-integral loop filter producing a bounded phase correction.
// Assumes CORR_W >= SOFT_W + 1 and CORR_MAX < 2**(CORR_W-1).
module costas_loop_filter #(
    parameter int SOFT_W   = 8,
    parameter int KP_SHIFT = 2,
    parameter int KI_SHIFT = 3,
    parameter int CORR_MAX = 2048,
    parameter int CORR_W   = 13
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     upd,
    input  logic signed [SOFT_W-1:0] i_lpf,
    input  logic signed [SOFT_W-1:0] q_lpf,
    output logic signed [CORR_W-1:0] corr
);
    localparam int SUM_W = CORR_W + 1;
    localparam logic signed [SUM_W-1:0] LIM = SUM_W'(CORR_MAX);

    logic signed [SOFT_W:0]   q_ext, err, err_p, err_i;
    logic signed [SUM_W-1:0]  p_ext, i_ext, integ_sum, corr_sum;
    logic signed [CORR_W-1:0] integ, integ_nxt, corr_nxt;

    // Clamp a wide value into the correction range.
    function automatic logic signed [CORR_W-1:0] sat(input logic signed [SUM_W-1:0] v);
        if (v > LIM)       return LIM[CORR_W-1:0];
        else if (v < -LIM) return (-LIM) >>> 0;
        else               return v[CORR_W-1:0];
    endfunction

    // Phase error (Q times sign of I) and the PI arithmetic.
    always_comb begin
        q_ext     = {q_lpf[SOFT_W-1], q_lpf};
        err       = i_lpf[SOFT_W-1] ? -q_ext : q_ext;
        err_p     = err >>> KP_SHIFT;
        err_i     = err >>> KI_SHIFT;
        p_ext     = {{(SUM_W - SOFT_W - 1){err_p[SOFT_W]}}, err_p};
        i_ext     = {{(SUM_W - SOFT_W - 1){err_i[SOFT_W]}}, err_i};
        integ_sum = {integ[CORR_W-1], integ} + i_ext;
        integ_nxt = sat(integ_sum);
        corr_sum  = {integ_nxt[CORR_W-1], integ_nxt} + p_ext;
        corr_nxt  = sat(corr_sum);
    end

    // Integrator and correction register, updated once per window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            integ <= '0;
            corr  <= '0;
        end else if (upd) begin
            integ <= integ_nxt;
            corr  <= corr_nxt;
        end
    end
endmodule

// File: rtl/costas_demod.sv
// Top of the Costas carrier demodulator: strobe window counter, NCO, arms and loop filter.
// Assumes samp_en pulses four times per carrier cycle and slice_in is valid when samp_en is high.
module costas_demod
    import costas_pkg::*;
#(
    parameter int PHASE_W   = 16,
    parameter int SOFT_W    = 8,
    parameter int GAIN_SH   = 5,
    parameter int LPF_SHIFT = 2,
    parameter int KP_SHIFT  = 2,
    parameter int KI_SHIFT  = 3,
    parameter int CORR_MAX  = 2048
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     samp_en,
    input  logic                     slice_in,
    output logic signed [SOFT_W-1:0] soft_i,
    output logic                     soft_valid,
    output logic                     carrier_out
);
    localparam int CORR_W = $clog2(CORR_MAX) + 2;

    logic [1:0]               win_cnt;
    logic                     win_end;
    quad_t                    quad;
    logic [1:0][SOFT_W-1:0]   arm_lpf;
    logic signed [SOFT_W-1:0] i_lpf, q_lpf;
    logic signed [CORR_W-1:0] corr;

    // The fourth strobe of each window closes it.
    always_comb win_end = samp_en && (win_cnt == 2'd3);

    // Count strobes within the window and raise the output strobe after each window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt    <= '0;
            soft_valid <= 1'b0;
        end else begin
            if (samp_en) win_cnt <= win_cnt + 2'd1;
            soft_valid <= win_end;
        end
    end

    costas_nco #(.PHASE_W(PHASE_W), .CORR_W(CORR_W)) nco_i (
        .clk(clk), .rst_n(rst_n), .step_en(samp_en), .corr(corr),
        .quad(quad), .carrier(carrier_out)
    );

    costas_arms #(.SOFT_W(SOFT_W), .GAIN_SH(GAIN_SH), .LPF_SHIFT(LPF_SHIFT)) arms_i (
        .clk(clk), .rst_n(rst_n), .step_en(samp_en), .win_end(win_end),
        .din(slice_in), .quad(quad), .lpf_out(arm_lpf)
    );

    // Split the packed arm outputs into signed values.
    always_comb begin
        i_lpf = arm_lpf[0];
        q_lpf = arm_lpf[1];
    end

    costas_loop_filter #(.SOFT_W(SOFT_W), .KP_SHIFT(KP_SHIFT), .KI_SHIFT(KI_SHIFT),
                         .CORR_MAX(CORR_MAX), .CORR_W(CORR_W)) loop_i (
        .clk(clk), .rst_n(rst_n), .upd(win_end), .i_lpf(i_lpf), .q_lpf(q_lpf), .corr(corr)
    );

    assign soft_i = i_lpf;
endmodule

// File: rtl/costas_demod_chk.sv
// Port-level checker for costas_demod, bound to every instance of the top module.
// Assumes reset is held low for at least one clock edge before use.
module costas_demod_chk #(
    parameter int SOFT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              samp_en,
    input logic [SOFT_W-1:0] soft_i,
    input logic              soft_valid,
    input logic              carrier_out
);
    localparam logic [SOFT_W-1:0] MOST_NEG = {1'b1, {(SOFT_W - 1){1'b0}}};

    logic       rst_seen_q = 1'b0;
    logic [2:0] strobes_q  = 3'd0;

    // Remember whether the previous edge was a reset edge.
    always_ff @(posedge clk) rst_seen_q <= !rst_n;

    // Count strobes since the last output pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) strobes_q <= '0;
        else        strobes_q <= (soft_valid ? 3'd0 : strobes_q) + {2'b0, samp_en};
    end

    // R1: outputs hold their reset values in the clock after a reset edge.
    always_ff @(posedge clk) begin
        if (rst_seen_q)
            a_r1_reset_state: assert (soft_i == '0 && !soft_valid && carrier_out)
                else $error("R1 reset state wrong");
    end

    // R4: each output pulse follows exactly four strobes.
    always_ff @(posedge clk) begin
        if (rst_n && soft_valid)
            a_r4_valid_cadence: assert (strobes_q == 3'd4)
                else $error("R4 pulse after %0d strobes", strobes_q);
    end

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        soft_valid |=> !soft_valid);

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        soft_i != MOST_NEG);

    a_r6_carrier_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(samp_en)) |-> $stable(carrier_out));

    a_r7_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(samp_en)) |-> ($stable(soft_i) && !soft_valid));
endmodule

bind costas_demod costas_demod_chk #(.SOFT_W(SOFT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .soft_i(soft_i),
    .soft_valid(soft_valid), .carrier_out(carrier_out)
);

// File: tb/costas_demod_tb_top.sv
// Scoreboard bench for costas_demod: drivers push expected soft samples, a monitor pops and compares.
module costas_demod_tb_top;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              samp_en = 1'b0;
    logic              slice_in = 1'b0;
    logic signed [7:0] soft_i;
    logic              soft_valid;
    logic              carrier_out;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;
    bit  sb_on = 1'b0;
    int  exp_q[$];

    logic last_car, prev_car, last_val;
    bit   rise_seen;
    int   since_rise, first_period, bad_periods, first_non4;

    always #10 clk = ~clk;

    costas_demod dut_i (
        .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .slice_in(slice_in),
        .soft_i(soft_i), .soft_valid(soft_valid), .carrier_out(carrier_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Monitor: compare every output pulse with the next expected item.
    always @(negedge clk) begin
        if (rst_n && soft_valid && sb_on) begin
            if (exp_q.size() == 0) chk(1'b0, "R4 unexpected soft_valid", 1, 0);
            else begin
                int e;
                e = exp_q.pop_front();
                chk(int'(soft_i) == e, "R3 soft_i", int'(soft_i), e);
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; samp_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(soft_i == 0, "R1 soft_i after reset", int'(soft_i), 0);
        chk(soft_valid == 1'b0, "R1 soft_valid after reset", int'(soft_valid), 0);
        chk(carrier_out == 1'b1, "R1 carrier after reset", int'(carrier_out), 1);
        rst_n = 1'b1;
        prev_car = 1'b1; rise_seen = 1'b0; since_rise = 0;
        first_period = 0; bad_periods = 0; first_non4 = 0;
    endtask

    // One strobe, then two idle clocks with the input inverted; tracks carrier periods.
    task automatic strobe(input logic b);
        @(negedge clk);
        samp_en = 1'b1; slice_in = b;
        @(negedge clk);
        samp_en = 1'b0; slice_in = ~b;
        last_car = carrier_out; last_val = soft_valid;
        since_rise++;
        if (!prev_car && last_car) begin
            if (rise_seen) begin
                if (since_rise < 3 || since_rise > 5) bad_periods++;
                if (since_rise != 4 && first_non4 == 0) first_non4 = since_rise;
            end else first_period = since_rise;
            rise_seen = 1'b1; since_rise = 0;
        end
        prev_car = last_car;
        @(negedge clk);
    endtask

    // Driver: run a pattern for a number of strobes; the pushed expectations go to the monitor.
    task automatic run_aligned(input int n, input bit invert);
        for (int k = 0; k < n; k++) strobe(((k % 4) < 2) ^ invert);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        // R2/R6: constant input gives zero sums and nominal four-strobe period.
        do_reset();
        sb_on = 1'b1;
        for (int w = 0; w < 10; w++) exp_q.push_back(0);
        for (int k = 0; k < 40; k++) begin
            strobe(1'b1);
            if (k == 3) chk(last_val == 1'b1, "R4 valid after 4th strobe", int'(last_val), 1);
            if (k == 2) chk(last_val == 1'b0, "R4 no valid after 3rd strobe", int'(last_val), 0);
        end
        chk(first_period == 4, "R6 first rise after 4th strobe", first_period, 4);
        chk(first_non4 == 0, "R6 nominal period with zero error", first_non4, 0);
        chk(exp_q.size() == 0, "R4 all DC windows reported", exp_q.size(), 0);
        do_reset();
        for (int w = 0; w < 5; w++) exp_q.push_back(0);
        for (int k = 0; k < 20; k++) strobe(1'b0);
        chk(exp_q.size() == 0, "R2 zero-input windows reported", exp_q.size(), 0);

        // R3: in-phase pattern, exact filter sequence.
        do_reset();
        exp_q.push_back(16); exp_q.push_back(28); exp_q.push_back(37);
        exp_q.push_back(43); exp_q.push_back(48);
        run_aligned(20, 1'b0);
        chk(exp_q.size() == 0, "R3 aligned windows reported", exp_q.size(), 0);

        // R7: with no strobe the toggling input changes nothing.
        begin
            int held_i;
            logic held_c;
            held_i = int'(soft_i); held_c = carrier_out;
            for (int c = 0; c < 12; c++) begin
                @(negedge clk);
                slice_in = ~slice_in;
                chk(int'(soft_i) == held_i, "R7 soft_i held", int'(soft_i), held_i);
                chk(carrier_out == held_c, "R7 carrier held", int'(carrier_out), int'(held_c));
                chk(soft_valid == 1'b0, "R7 no valid", int'(soft_valid), 0);
            end
        end

        // R3: anti-phase pattern, arithmetic-shift rounding toward minus infinity.
        do_reset();
        exp_q.push_back(-16); exp_q.push_back(-28); exp_q.push_back(-37);
        exp_q.push_back(-44); exp_q.push_back(-49);
        run_aligned(20, 1'b1);
        chk(exp_q.size() == 0, "R3 inverted windows reported", exp_q.size(), 0);
        sb_on = 1'b0;

        // R5: positive error pulls the carrier ahead; periods stay in 3..5.
        do_reset();
        run_aligned(1200, 1'b0);
        chk(first_non4 == 3, "R5 first off-nominal period", first_non4, 3);
        chk(bad_periods == 0, "R5 periods within 3..5", bad_periods, 0);

        // R1: reset mid-run restarts phase and loop state exactly.
        do_reset();
        sb_on = 1'b1;
        exp_q.push_back(16); exp_q.push_back(28);
        run_aligned(8, 1'b0);
        chk(exp_q.size() == 0, "R1 restart sequence reported", exp_q.size(), 0);
        sb_on = 1'b0;

        finish_run();
    end
endmodule